// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the single-cycle arithmetic and logic stage of a small 8-bit processor datapath. It takes a first operand, a second operand that can come either from a register or from an immediate field, an incoming carry, a 4-bit operation code and the current six status flags. From these it produces a result, a result write-enable and the next value of the six flags, all within the same cycle. The block is purely combinational, so the surrounding pipeline registers both the result and the flags.

Each operation changes only its own subset of the flags and passes the others through unchanged. The compare operations report flags but suppress the result write. The zero flag of the with-carry subtract and compare operations is sticky: it can only stay set or be cleared. Chained byte-wide operations therefore give a correct zero indication for a multi-byte value.

The flag vector uses these bit positions: bit 0 is C (carry/borrow), bit 1 is Z (zero), bit 2 is N (negative), bit 3 is V (two's-complement overflow), bit 4 is S (sign, N xor V) and bit 5 is H (carry/borrow out of bit 3).

Top module: `alu_flags`

## Requirements
- R1: Op 0 (add) gives A+B and op 1 (add with carry) gives A+B+carry_i, truncated to 8 bits. Both write the result and update all six flags: C is the carry out of bit 7, H is the carry out of bit 3, V is set when two operands of equal sign give a result of the other sign, N is result bit 7, and Z is set when the result is zero.
- R2: Op 2 (subtract) gives A−B and op 3 (subtract with carry) gives A−B−carry_i. Both write the result and update all six flags: C is the borrow out of bit 7, H is the borrow out of bit 3, and V is set when operands of different sign give a result whose sign differs from A.
- R3: For op 3 and op 13, the Z output is set only when the 8-bit result is zero and the incoming Z (flags_i bit 1) is set.
- R4: Op 12 (compare) and op 13 (compare with carry) produce the same result value and flags as op 2 and op 3, but keep wr_en_o low.
- R5: Ops 4, 5 and 6 give A AND B, A OR B and A XOR B. They write the result, set V to 0, update Z, N and S, and keep C and H at their incoming values.
- R6: Op 7 (one's complement) gives 0xFF−A. It sets C to 1 and V to 0, updates Z, N and S, and keeps H.
- R7: Op 8 (two's complement) gives 0x00−A. It updates all six flags as a subtraction of A from zero: C is set for any nonzero A, and V is set only for A=0x80.
- R8: Op 9 (increment) gives A+1 and op 10 (decrement) gives A−1. They update Z, N, V and S, with V set only for the 0x7F→0x80 (increment) and 0x80→0x7F (decrement) transitions, and keep C and H.
- R9: Op 11 (set all) writes 0xFF and returns flags_o equal to flags_i.
- R10: When use_imm_i is 1, imm_i takes the place of b_i as the second operand in every operation that uses one. When use_imm_i is 0, b_i is used.
- R11: Op codes 14 and 15 are unused. They give result 0, keep wr_en_o low and return flags_o equal to flags_i.
- R12: For every op that updates flags, S equals N xor V of the outgoing flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand from the register path |
| imm_i | input | 8 | Second operand from the immediate path |
| use_imm_i | input | 1 | Selects imm_i instead of b_i |
| carry_i | input | 1 | Incoming carry for the with-carry operations |
| op_i | input | 4 | Operation code (0 to 15) |
| flags_i | input | 6 | Current flags {H,S,V,N,Z,C} |
| res_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 6 | Next flags {H,S,V,N,Z,C} |

## Verification
The checker assumes that every input carries a known 0 or 1 value. Its immediate assertions are evaluated only while none of the inputs is unknown, which excludes the moment before the bench first drives them. The bench drives all inputs from the first cycle on and never leaves a bit undriven. It covers every first-operand value, a set of edge and related second-operand values, both carry values and all sixteen op codes. The incoming flag pattern rotates so that both states of the sticky Z input are exercised.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             carry_i,
  input  logic [3:0]       op_i,
  input  logic [5:0]       flags_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wr_en_o,
  output logic [5:0]       flags_o
);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  localparam logic [5:0] UPD_ALL   = 6'b111111;
  localparam logic [5:0] UPD_LOGIC = 6'b011110;
  localparam logic [5:0] UPD_COM   = 6'b011111;

  logic [WIDTH-1:0] opb;
  assign opb = use_imm_i ? imm_i : b_i;

  logic [WIDTH-1:0] ax, ay, sx, sy;
  logic             ac, sc;
  logic [WIDTH:0]   add_full, sub_full;
  logic [HALF:0]    add_half, sub_half;

  always_comb begin
    ax = a_i;
    ay = (op_i == 4'd9) ? ONE : opb;
    ac = (op_i == 4'd1) ? carry_i : 1'b0;
    sx = a_i;
    sy = opb;
    sc = (op_i == 4'd3 || op_i == 4'd13) ? carry_i : 1'b0;
    case (op_i)
      4'd7:    begin sx = ONES; sy = a_i; end
      4'd8:    begin sx = '0;   sy = a_i; end
      4'd10:   sy = ONE;
      default: ;
    endcase
  end

  assign add_full = {1'b0, ax} + {1'b0, ay} + {{WIDTH{1'b0}}, ac};
  assign add_half = {1'b0, ax[HALF-1:0]} + {1'b0, ay[HALF-1:0]} + {{HALF{1'b0}}, ac};
  assign sub_full = {1'b0, sx} - {1'b0, sy} - {{WIDTH{1'b0}}, sc};
  assign sub_half = {1'b0, sx[HALF-1:0]} - {1'b0, sy[HALF-1:0]} - {{HALF{1'b0}}, sc};

  logic add_v, sub_v;
  assign add_v = (ax[MSB] == ay[MSB]) && (add_full[MSB] != ax[MSB]);
  assign sub_v = (sx[MSB] != sy[MSB]) && (sub_full[MSB] != sx[MSB]);

  logic [5:0] upd;
  logic       c_n, h_n, v_n, z_keep;

  always_comb begin
    res_o   = '0;
    wr_en_o = 1'b1;
    upd     = UPD_LOGIC;
    c_n     = flags_i[0];
    h_n     = flags_i[5];
    v_n     = 1'b0;
    z_keep  = 1'b1;
    case (op_i)
      4'd0, 4'd1: begin
        res_o = add_full[MSB:0]; upd = UPD_ALL;
        c_n = add_full[WIDTH]; h_n = add_half[HALF]; v_n = add_v;
      end
      4'd2, 4'd3, 4'd8, 4'd12, 4'd13: begin
        res_o = sub_full[MSB:0]; upd = UPD_ALL;
        c_n = sub_full[WIDTH]; h_n = sub_half[HALF]; v_n = sub_v;
        wr_en_o = !(op_i == 4'd12 || op_i == 4'd13);
        z_keep  = (op_i == 4'd3 || op_i == 4'd13) ? flags_i[1] : 1'b1;
      end
      4'd4:  res_o = a_i & opb;
      4'd5:  res_o = a_i | opb;
      4'd6:  res_o = a_i ^ opb;
      4'd7: begin
        res_o = sub_full[MSB:0]; upd = UPD_COM; c_n = 1'b1;
      end
      4'd9:  begin res_o = add_full[MSB:0]; v_n = add_v; end
      4'd10: begin res_o = sub_full[MSB:0]; v_n = sub_v; end
      4'd11: begin res_o = ONES; upd = '0; end
      default: begin wr_en_o = 1'b0; upd = '0; end
    endcase
  end

  logic       n_n, z_n;
  logic [5:0] fresh;
  assign n_n     = res_o[MSB];
  assign z_n     = (res_o == '0) && z_keep;
  assign fresh   = {h_n, n_n ^ v_n, v_n, n_n, z_n, c_n};
  assign flags_o = (fresh & upd) | (flags_i & ~upd);
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] imm_i,
  input logic             use_imm_i,
  input logic             carry_i,
  input logic [3:0]       op_i,
  input logic [5:0]       flags_i,
  input logic [WIDTH-1:0] res_o,
  input logic             wr_en_o,
  input logic [5:0]       flags_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, imm_i, use_imm_i, carry_i, op_i, flags_i});

  always_comb begin
    if (known) begin
      if (op_i == 4'd12 || op_i == 4'd13)
        assert_cmp_no_write_R4: assert (!wr_en_o);
      if (op_i >= 4'd4 && op_i <= 4'd6)
        assert_logic_keeps_ch_R5: assert (!flags_o[3] && flags_o[0] == flags_i[0] && flags_o[5] == flags_i[5]);
      if (op_i == 4'd7)
        assert_com_sets_c_R6: assert (flags_o[0] && !flags_o[3] && flags_o[5] == flags_i[5]);
      if (op_i == 4'd9 || op_i == 4'd10)
        assert_incdec_keeps_c_R8: assert (flags_o[0] == flags_i[0] && flags_o[5] == flags_i[5]);
      if (op_i == 4'd11)
        assert_set_all_R9: assert (res_o == '1 && flags_o == flags_i && wr_en_o);
      if (op_i >= 4'd14)
        assert_unused_idle_R11: assert (!wr_en_o && flags_o == flags_i);
      if (op_i <= 4'd10 || op_i == 4'd12 || op_i == 4'd13)
        assert_sign_rule_R12: assert (flags_o[4] == (flags_o[2] ^ flags_o[3]));
      if ((op_i == 4'd3 || op_i == 4'd13) && !flags_i[1])
        assert_sticky_zero_R3: assert (!flags_o[1]);
    end
  end
endmodule

bind alu_flags alu_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
  .carry_i(carry_i), .op_i(op_i), .flags_i(flags_i),
  .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
);

// File: tb/sim_alu_flags.sv
module sim_alu_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a, b, imm, res;
  logic       use_imm, cin, we;
  logic [3:0] op;
  logic [5:0] fin, fout;

  alu_flags u0 (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm), .carry_i(cin),
    .op_i(op), .flags_i(fin), .res_o(res), .wr_en_o(we), .flags_o(fout)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // returns {h, v, c, r[7:0]}
  function automatic logic [10:0] add8(int x, int y, int c);
    int s = x + y + c;
    int r = s & 255;
    logic v = (((x >> 7) & 1) == ((y >> 7) & 1)) && (((r >> 7) & 1) != ((x >> 7) & 1));
    return {((x & 15) + (y & 15) + c) > 15, v, s > 255, 8'(r)};
  endfunction

  function automatic logic [10:0] sub8(int x, int y, int c);
    int d = x - y - c;
    int r = d & 255;
    logic v = (((x >> 7) & 1) != ((y >> 7) & 1)) && (((r >> 7) & 1) != ((x >> 7) & 1));
    return {((x & 15) - (y & 15) - c) < 0, v, d < 0, 8'(r)};
  endfunction

  // returns {we, res[7:0], flags[5:0]}
  function automatic logic [14:0] model(int o, int x, int y, int ci, logic [5:0] f);
    logic [10:0] t = '0;
    logic [5:0]  m = 6'b011110;
    logic        w = 1'b1, c = f[0], h = f[5], v = 1'b0, z, n;
    int          r = 0;
    case (o)
      0, 1: begin t = add8(x, y, (o == 1) ? ci : 0); m = 6'h3F; end
      2, 3, 12, 13: begin t = sub8(x, y, (o == 3 || o == 13) ? ci : 0); m = 6'h3F; w = (o < 12); end
      8: begin t = sub8(0, x, 0); m = 6'h3F; end
      default: ;
    endcase
    if (m == 6'h3F) begin r = int'(t[7:0]); c = t[8]; v = t[9]; h = t[10]; end
    case (o)
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      7: begin r = 255 - x; c = 1'b1; m = 6'b011111; end
      9: begin r = (x + 1) & 255; v = (x == 127); end
      10: begin r = (x + 255) & 255; v = (x == 128); end
      11: begin r = 255; m = 6'b0; end
      14, 15: begin r = 0; w = 1'b0; m = 6'b0; end
      default: ;
    endcase
    z = (r == 0);
    if (o == 3 || o == 13) z = z && f[1];
    n = r[7];
    return {w, 8'(r), ({h, n ^ v, v, n, z, c} & m) | (f & ~m)};
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4, 5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9, 10: return "R8";
      11: return "R9";
      12, 13: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0d fin=%b act=%h exp=%h",
               tag, op, a, b, cin, fin, act, exp);
    end
  endtask

  task automatic apply(int o, int x, int y, int ci, logic [5:0] f, bit imm_path);
    @(negedge clk);
    op = 4'(o); a = 8'(x); cin = ci[0]; fin = f; use_imm = imm_path;
    if (imm_path) begin imm = 8'(y); b = ~8'(y); end
    else begin b = 8'(y); imm = 8'(y + 91); end
    #1;
    check(tag_of(o), {we, res, fout}, model(o, x, y, ci, f));
    if (o <= 10 || o == 12 || o == 13) begin
      checks++;
      if (fout[4] !== (fout[2] ^ fout[3])) begin
        failures++;
        $display("FAIL R12 op=%0d act S=%b expected N^V=%b", o, fout[4], fout[2] ^ fout[3]);
      end
    end
  endtask

  initial begin
    a = 0; b = 0; imm = 0; use_imm = 0; cin = 0; op = 0; fin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: immediate path replaces b_i, register path ignores imm_i
    apply(0, 8'h10, 8'h01, 0, 6'h00, 1'b1);
    apply(0, 8'h10, 8'h01, 0, 6'h00, 1'b0);
    apply(12, 8'h05, 8'h05, 0, 6'h00, 1'b1);
    // R3: sticky zero both ways
    apply(13, 8'h33, 8'h33, 0, 6'h02, 1'b0);
    apply(13, 8'h33, 8'h33, 0, 6'h00, 1'b0);
    for (int x = 0; x < 256; x++) begin
      for (int bi = 0; bi < 10; bi++) begin
        int y;
        case (bi)
          0: y = 0;    1: y = 1;    2: y = 15;   3: y = 16;  4: y = 127;
          5: y = 128;  6: y = 129;  7: y = 255;  8: y = x;   default: y = x ^ 85;
        endcase
        for (int o = 0; o < 16; o++)
          for (int ci = 0; ci < 2; ci++)
            apply(o, x, y, ci, 6'((x * 7 + bi * 13 + o * 5 + ci) & 63), ((x + bi + o) & 1) == 1);
      end
    end
    done = 1;
  end

  initial begin
    for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule